// File: doc/BRIEF.md
# Low-Power Oscillator Control and Start-Up Sequencer

This block holds the single 32-bit control word for an on-chip 32.768 kHz low-power oscillator and turns that word into the enable for the analog core, a ready flag and two gated clock outputs. Software writes the word through a plain write strobe with a data bus. The stored value is always visible on the read bus. The word carries a calibration trim, a sticky lock, a 3-bit start-up delay code, two sleep-policy bits that pass straight to the sleep logic, two output enables and the oscillator enable.

When software sets the enable bit, a start-up counter loads the delay selected by the code. The counter advances only on tick pulses from a separate always-on slow clock, because the oscillator being started cannot be trusted yet. When the count runs out, the ready flag rises. Only then may the 32.768 kHz enable and the 1.024 kHz tick leave the block. The 1.024 kHz tick is made by dividing oscillator-cycle pulses by 32. Clearing the enable bit withdraws everything at once.

Once the lock bit has been written, the configuration is frozen until the next reset.

Top module: `slowosc_ctrl`

## Requirements
- R1: After reset, rd_data is 0x00000080 (on_demand is 1, every other field is 0), and ready, clk32k_en, tick1k and osc_on are all 0.
- R2: The writable fields are at fixed positions: trim in bits 22:16, lock in bit 12, delay code in bits 10:8, on-demand in bit 7, run-in-standby in bit 6, 1.024 kHz enable in bit 3, 32.768 kHz enable in bit 2 and oscillator enable in bit 1. Every other bit reads 0 and ignores writes, so the write mask is 0x007F17CE. osc_calib, on_demand, run_standby and osc_on show the stored fields.
- R3: An accepted write whose bit 12 is 1 stores all of its fields. From the next cycle until reset, every write is ignored, and the lock bit itself cannot be cleared by a write.
- R4: A write that changes the enable bit from 0 to 1 clears ready and loads a delay of 2^code + 2 slow ticks, using the code carried by that same write. A slow_tick sampled on the loading edge does not count. ready rises on the clock edge that samples the last counted slow_tick. osc_tick pulses have no effect on the delay.
- R5: Changing the delay code while the oscillator is enabled, before or after ready, neither restarts nor changes the countdown in progress. Rewriting enable = 1 while it is already 1 also leaves the countdown alone.
- R6: A write that clears the enable bit drops osc_on and ready on that write's clock edge. clk32k_en follows on the same edge.
- R7: clk32k_en is 1 exactly when ready is 1 and bit 2 is 1.
- R8: While ready was 1 in the previous cycle, a divider counts osc_tick pulses modulo 32. tick1k is a one-cycle pulse, one cycle after every 32nd counted pulse, provided bit 3 was set. The divider restarts from 0 whenever ready has been low, so the first tick1k after ready needs 32 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored control word |
| slow_tick | input | 1 | One-cycle pulse per always-on slow-clock cycle |
| osc_tick | input | 1 | One-cycle pulse per oscillator cycle |
| osc_on | output | 1 | Enable to the analog oscillator |
| osc_calib | output | 7 | Calibration trim to the analog oscillator |
| on_demand | output | 1 | On-demand policy bit to sleep logic |
| run_standby | output | 1 | Run-in-standby policy bit to sleep logic |
| ready | output | 1 | Start-up delay has elapsed |
| clk32k_en | output | 1 | Gated 32.768 kHz output enable |
| tick1k | output | 1 | 1.024 kHz pulse, oscillator cycles divided by 32 |

## Verification
Every delay code from 0 to 7 is started from a disabled state with slow ticks arriving every third cycle and osc_tick pulses running in between. This separates a correct 2^code + 2 delay from an off-by-one or a counter clocked by the wrong tick. Delay-code rewrites during a countdown, and repeated enable writes, distinguish a latched code from a live one. Disabling mid-countdown and after ready shows whether the output gating and the divider restart track the enable. A final all-ones write followed by a clearing write checks the write mask and the lock in one pattern.

// File: rtl/slowosc_pkg.sv
// Package: shared layout of the oscillator control word.
// Assumes a 32-bit word; field positions are fixed by software.
package slowosc_pkg;

    localparam int WORD_W     = 32;
    localparam int TRIM_W     = 7;
    localparam int CODE_W     = 3;
    localparam int DELAY_BASE = 2;

    // Bit positions of every field in the control word
    localparam int POS_TRIM   = 16;
    localparam int POS_LOCK   = 12;
    localparam int POS_CODE   = 8;
    localparam int POS_ONDMD  = 7;
    localparam int POS_STDBY  = 6;
    localparam int POS_EN1K   = 3;
    localparam int POS_EN32K  = 2;
    localparam int POS_ENABLE = 1;

    localparam logic [WORD_W-1:0] WR_MASK   = 32'h007F_17CE;
    localparam logic [WORD_W-1:0] RESET_VAL = 32'h0000_0080;

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
        logic              lock;
        logic [CODE_W-1:0] code;
        logic              ondmd;
        logic              stdby;
        logic              en1k;
        logic              en32k;
        logic              enable;
    } ctrl_t;

    // Extract fields from a bus word
    function automatic ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.trim   = w[POS_TRIM +: TRIM_W];
        c.lock   = w[POS_LOCK];
        c.code   = w[POS_CODE +: CODE_W];
        c.ondmd  = w[POS_ONDMD];
        c.stdby  = w[POS_STDBY];
        c.en1k   = w[POS_EN1K];
        c.en32k  = w[POS_EN32K];
        c.enable = w[POS_ENABLE];
        return c;
    endfunction

    // Place fields back on a bus word, unused bits zero
    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_TRIM +: TRIM_W] = c.trim;
        w[POS_LOCK]           = c.lock;
        w[POS_CODE +: CODE_W] = c.code;
        w[POS_ONDMD]          = c.ondmd;
        w[POS_STDBY]          = c.stdby;
        w[POS_EN1K]           = c.en1k;
        w[POS_EN32K]          = c.en32k;
        w[POS_ENABLE]         = c.enable;
        return w;
    endfunction

endpackage

// File: rtl/slowosc_ctrl_reg.sv
// Module: control word storage with sticky lock.
// Does: accepts a write while unlocked and exposes both the stored value and
// the value the next edge will store, so that later stages act on the same edge.
// Assumes: one write port, so a locking write is the only write of its cycle.
module slowosc_ctrl_reg
    import slowosc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_next,
    output logic              en_rise,
    output logic [WORD_W-1:0] rd_data
);

    logic accept;

    // Decide whether this cycle's write lands and what the word becomes
    always_comb begin
        accept    = wr_en && !ctrl_q.lock;
        ctrl_next = accept ? word_to_ctrl(wr_data & WR_MASK) : ctrl_q;
    end

    // Store the word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= word_to_ctrl(RESET_VAL);
        end else begin
            ctrl_q <= ctrl_next;
        end
    end

    // Flag the edge on which the enable turns on
    assign en_rise = ctrl_next.enable && !ctrl_q.enable;
    // Read bus always shows the stored word
    assign rd_data = ctrl_to_word(ctrl_q);

endmodule

// File: rtl/slowosc_startup.sv
// Module: start-up delay counter.
// Does: on an enable rising edge loads 2^code + DELAY_BASE, counts down on slow
// ticks, and raises ready when the count is used up.
// Assumes: slow_tick is a one-cycle pulse already in the clk domain.
module slowosc_startup
    import slowosc_pkg::*;
#(
    parameter int N_CODE_BITS = CODE_W,
    parameter int BASE        = DELAY_BASE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_next,
    input  logic                   en_rise,
    input  logic [N_CODE_BITS-1:0] code,
    input  logic                   slow_tick,
    output logic                   ready
);

    localparam int N_CODES   = 1 << N_CODE_BITS;
    localparam int MAX_DELAY = (1 << (N_CODES - 1)) + BASE;
    localparam int CNT_W     = $clog2(MAX_DELAY + 1);

    logic [CNT_W-1:0] delay_lut [N_CODES];
    logic [CNT_W-1:0] cnt_q;

    // Delay for each code, computed per entry
    for (genvar g = 0; g < N_CODES; g++) begin : g_lut
        assign delay_lut[g] = CNT_W'((1 << g) + BASE);
    end

    // Load, count down, and raise ready on the last counted tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (!en_next) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (en_rise) begin
            cnt_q <= delay_lut[code];
            ready <= 1'b0;
        end else if (!ready && slow_tick) begin
            if (cnt_q == CNT_W'(1)) begin
                cnt_q <= '0;
                ready <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/slowosc_clkout.sv
// Module: output gating and 1.024 kHz divider.
// Does: gates the full-rate enable with ready and divides oscillator pulses by
// DIV_RATIO to make a registered one-cycle tick.
// Assumes: osc_tick marks one oscillator cycle; ready comes from a register.
module slowosc_clkout #(
    parameter int DIV_RATIO = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic en32k,
    input  logic en1k,
    input  logic osc_tick,
    output logic clk32k_en,
    output logic tick1k
);

    localparam int DIV_W = $clog2(DIV_RATIO);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

    logic [DIV_W-1:0] div_q;
    logic             wrap;

    assign wrap = ready && osc_tick && (div_q == DIV_LAST);

    // Count oscillator pulses only while ready, else hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!ready) begin
            div_q <= '0;
        end else if (osc_tick) begin
            div_q <= wrap ? '0 : div_q + DIV_W'(1);
        end
    end

    // Register the divided tick when its enable is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick1k <= 1'b0;
        end else begin
            tick1k <= wrap && en1k;
        end
    end

    // Full-rate enable passes only once ready
    assign clk32k_en = ready && en32k;

endmodule

// File: rtl/slowosc_ctrl.sv
// Module: top of the low-power oscillator control block.
// Does: ties the control word, start-up counter and output stage together.
// Assumes: slow_tick and osc_tick are synchronised one-cycle pulses.
module slowosc_ctrl
    import slowosc_pkg::*;
#(
    parameter int DIV_RATIO = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              slow_tick,
    input  logic              osc_tick,
    output logic              osc_on,
    output logic [TRIM_W-1:0] osc_calib,
    output logic              on_demand,
    output logic              run_standby,
    output logic              ready,
    output logic              clk32k_en,
    output logic              tick1k
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_next;
    logic  en_rise;

    slowosc_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .ctrl_next (ctrl_next),
        .en_rise   (en_rise),
        .rd_data   (rd_data)
    );

    slowosc_startup #(
        .N_CODE_BITS (CODE_W),
        .BASE        (DELAY_BASE)
    ) u_startup (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_next   (ctrl_next.enable),
        .en_rise   (en_rise),
        .code      (ctrl_next.code),
        .slow_tick (slow_tick),
        .ready     (ready)
    );

    slowosc_clkout #(
        .DIV_RATIO (DIV_RATIO)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .en32k     (ctrl_q.en32k),
        .en1k      (ctrl_q.en1k),
        .osc_tick  (osc_tick),
        .clk32k_en (clk32k_en),
        .tick1k    (tick1k)
    );

    // Stored fields drive the analog core and sleep logic directly
    assign osc_on      = ctrl_q.enable;
    assign osc_calib   = ctrl_q.trim;
    assign on_demand   = ctrl_q.ondmd;
    assign run_standby = ctrl_q.stdby;

endmodule

// File: rtl/slowosc_ctrl_chk.sv
// Module: property checker for slowosc_ctrl, attached by bind.
// Assumes: port names match the top module's ports.
module slowosc_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] rd_data,
    input logic        slow_tick,
    input logic        osc_on,
    input logic        ready,
    input logic        clk32k_en,
    input logic        tick1k
);

    // R2: bits outside the mask never read as one
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~32'h007F_17CE) == 32'h0);

    // R3: a locked word never changes
    assert_lock_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[12] |=> $stable(rd_data));

    // R4: ready rises only on a sampled slow tick
    assert_ready_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(slow_tick));

    // R6: ready never stands without the oscillator on
    assert_ready_needs_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> osc_on);

    // R7: full-rate enable never leaves before ready
    assert_gate_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk32k_en |-> ready);

    // R8: the divided tick is a single-cycle pulse
    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick1k |=> !tick1k);

endmodule

bind slowosc_ctrl slowosc_ctrl_chk u_chk (.*);

// File: tb/tb_slowosc_ctrl.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module tb_slowosc_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam logic [31:0] MASK = 32'h007F_17CE;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        slow_tick;
    logic        osc_tick;
    logic        osc_on;
    logic [6:0]  osc_calib;
    logic        on_demand;
    logic        run_standby;
    logic        ready;
    logic        clk32k_en;
    logic        tick1k;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit armed    = 0;
    bit done     = 0;
    int n_ticks1k = 0;

    // Reference model state
    logic [31:0] m_reg;
    int          m_cnt;
    bit          m_rdy;
    int          m_div;
    bit          m_tick;

    slowosc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .slow_tick(slow_tick), .osc_tick(osc_tick),
        .osc_on(osc_on), .osc_calib(osc_calib), .on_demand(on_demand),
        .run_standby(run_standby), .ready(ready), .clk32k_en(clk32k_en),
        .tick1k(tick1k)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    // Model update at each edge, from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 32'h80; m_cnt = 0; m_rdy = 0; m_div = 0; m_tick = 0;
        end else begin
            logic [31:0] nreg;
            bit ntick;
            int ndiv;
            nreg  = (wr_en && !m_reg[12]) ? (wr_data & MASK) : m_reg;
            ntick = m_rdy && osc_tick && (m_div == 31) && m_reg[3];
            ndiv  = m_rdy ? (osc_tick ? (m_div + 1) % 32 : m_div) : 0;
            if (!nreg[1]) begin
                m_cnt = 0; m_rdy = 0;
            end else if (!m_reg[1]) begin
                m_cnt = (1 << nreg[10:8]) + 2; m_rdy = 0;
            end else if (!m_rdy && slow_tick) begin
                if (m_cnt == 1) begin m_rdy = 1; m_cnt = 0; end
                else m_cnt = m_cnt - 1;
            end
            m_reg = nreg; m_div = ndiv; m_tick = ntick;
        end
    end

    // Compare on every clock, then drive the free-running tick pattern
    always @(negedge clk) begin
        cyc++;
        if (armed && !done) begin
            check(rd_data == m_reg, "R2", "rd_data", rd_data, m_reg);
            check(osc_calib == m_reg[22:16] && on_demand == m_reg[7] &&
                  run_standby == m_reg[6], "R2", "field outputs",
                  {osc_calib, on_demand, run_standby}, {m_reg[22:16], m_reg[7], m_reg[6]});
            check(osc_on == m_reg[1], "R6", "osc_on", osc_on, m_reg[1]);
            check(ready == m_rdy, "R4", "ready", ready, m_rdy);
            check(clk32k_en == (m_rdy && m_reg[2]), "R7", "clk32k_en",
                  clk32k_en, m_rdy && m_reg[2]);
            check(tick1k == m_tick, "R8", "tick1k", tick1k, m_tick);
            if (tick1k) n_ticks1k++;
        end
        slow_tick <= (cyc % 3 == 0);
        osc_tick  <= (cyc % 2 == 0) || (cyc % 7 == 3);
    end

    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        wr_en   <= 1'b1;
        wr_data <= d;
        @(negedge clk);
        wr_en   <= 1'b0;
        wr_data <= '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; slow_tick = 1'b0; osc_tick = 1'b0;
        idle(3);
        rst_n <= 1'b1;
        armed = 1;
        @(negedge clk);
        // R1: reset state
        check(rd_data == 32'h80 && !ready && !clk32k_en && !tick1k && !osc_on,
              "R1", "reset state", rd_data, 32'h80);

        // R4, R7, R8: longest delay with both outputs enabled, mask exercised
        write_word(32'hFFFF_EFFF);
        check(!ready, "R4", "ready right after enable", ready, 0);
        idle(450);
        check(ready && clk32k_en, "R7", "gate after long delay", {ready, clk32k_en}, 2'b11);
        check(n_ticks1k > 0, "R8", "divided ticks seen", n_ticks1k, 1);

        // R6: disable while ready
        write_word(32'h0000_000C);
        check(!ready && !clk32k_en && !osc_on, "R6", "outputs after disable",
              {ready, clk32k_en, osc_on}, 0);

        // R5: code change and repeated enable during a countdown
        write_word(32'h0000_030E);
        idle(8);
        write_word(32'h0000_060E);
        idle(4);
        write_word(32'h0000_060A);
        idle(40);
        check(ready, "R5", "code change mid-countdown keeps delay", ready, 1);
        write_word(32'h0000_070E);
        check(ready, "R5", "code change after ready", ready, 1);
        idle(70);

        // R4: every code from a disabled state
        for (int c = 0; c < 8; c++) begin
            write_word(32'h0000_0000);
            write_word(32'h0001_004E | (c << 8));
            idle(((1 << c) + 2) * 3 + 40);
            check(ready, "R4", "ready after code delay", c, 1);
        end

        // R6: disable mid-countdown
        write_word(32'h0);
        write_word(32'h0000_050E);
        idle(20);
        write_word(32'h0);
        check(!ready && !osc_on, "R6", "disable mid-countdown", {ready, osc_on}, 0);

        // R3: locking write with all ones, then attempts to change it
        write_word(32'hFFFF_FFFF);
        check(rd_data == MASK, "R3", "locking write stored", rd_data, MASK);
        write_word(32'h0);
        check(rd_data == MASK, "R3", "write ignored after lock", rd_data, MASK);
        idle(450);
        write_word(32'h0000_0080);
        check(rd_data == MASK && ready, "R3", "still locked and ready", rd_data, MASK);

        // R1: reset clears the lock
        @(negedge clk);
        rst_n <= 1'b0;
        idle(2);
        rst_n <= 1'b1;
        @(negedge clk);
        check(rd_data == 32'h80 && !ready && !osc_on, "R1", "state after second reset",
              rd_data, 32'h80);
        write_word(32'h0000_0002);
        check(rd_data == 32'h2, "R3", "writes accepted after reset", rd_data, 32'h2);
        idle(20);
        finish_run();
    end

endmodule